// File: doc/BRIEF.md
# Consumer-Infrared UART Interrupt Controller

This block holds the interrupt enable and cause logic for a UART running in consumer-infrared mode. The receive and transmit datapaths report their state as levels and single-cycle event strobes: receive data available (two alternative levels, chosen by whether the FIFOs are on), transmit space available (likewise), a receive-stop event, a receive overrun and the end of a transmitted frame. Software reads an 8-bit cause register and programs an 8-bit enable register over a small register bus. The block drives one interrupt line.

The two space and data sources are live levels: they clear only when the datapath condition goes away. The receive-stop and frame-done sources are sticky and clear when the cause register is read. Overrun is sticky and clears only when a separate release address is read. The bus also reaches the receive and transmit holding registers. A read of offset 0 pulses `rx_pop` and returns `rx_data`. A write to offset 0 pulses `tx_push` with `tx_data`. These strobes are single-cycle and the datapath always takes them, so there is no back-pressure. Read data appears on `bus_rdata` one cycle after the read strobe.

Top module: `cir_irq_ctrl`

## Requirements
- R1: Cause bit 0 equals `rx_ready` when `fifo_on` is 0 and equals `rx_above_trig` when `fifo_on` is 1. It is not latched.
- R2: Cause bit 1 equals `tx_empty` when `fifo_on` is 0 and equals `tx_below_trig` when `fifo_on` is 1. It is not latched.
- R3: Cause bit 2 sets on the clock edge that samples `rx_stop_evt` high. It clears on the edge that samples a read of offset 2 (cause).
- R4: Cause bit 3 sets on the edge that samples `rx_ovr_evt` high. It clears only on a read of offset 3 (release), which returns 0x00. A cause read leaves it set.
- R5: Cause bit 5 sets on the edge that samples `tx_done_evt` high. It clears on a cause read.
- R6: Cause bits 4, 6 and 7 always read as 0.
- R7: The enable register sits at offset 1 and resets to 0x00. Only bits 0, 1, 2, 3 and 5 are writable. The other bits read as 0.
- R8: `irq` is high exactly when some cause bit and the matching enable bit are both 1. Sticky bits latch while disabled, so enabling one later raises `irq` as soon as the enable write completes.
- R9: If a sticky bit's set event and its clearing read are sampled on the same edge, the bit stays set.
- R10: Read data for the strobe sampled on an edge appears on `bus_rdata` after that edge. It holds the register value from before any clear. A read of offset 0 returns `rx_data` and drives `rx_pop` high during the strobe.
- R11: A write to offset 0 drives `tx_push` high and `tx_data` equal to `bus_wdata` during the strobe. Writes to offsets 2 and 3 change nothing.
- R12: A synchronous active-high `rst` clears all sticky bits, the enable register and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| fifo_on | input | 1 | FIFOs enabled; selects level sources |
| rx_ready | input | 1 | Receive data ready (FIFOs off) |
| rx_above_trig | input | 1 | RX FIFO above trigger level (FIFOs on) |
| tx_empty | input | 1 | Transmit holding register empty (FIFOs off) |
| tx_below_trig | input | 1 | TX FIFO below trigger level (FIFOs on) |
| rx_stop_evt | input | 1 | Receive-stop event strobe |
| rx_ovr_evt | input | 1 | Receive overrun event strobe |
| tx_done_evt | input | 1 | Last frame bit sent strobe |
| rx_data | input | 8 | Receive holding register contents |
| rx_pop | output | 1 | Receive holding register read strobe |
| tx_push | output | 1 | Transmit holding register write strobe |
| tx_data | output | 8 | Transmit data |
| irq | output | 1 | Interrupt request |

## Verification
The bench attacks the clearing rules. A design that cleared overrun on a cause read would lose the bit before its release read. A design that gave clear priority over set would drop a receive-stop event arriving with the read. A design that latched the level sources would keep bit 0 high after the data was drained. The bench also enables a source after its event has already latched: a design that gated the sticky bits with their enables before latching would never raise `irq`. It also writes all ones to the enable register and drives every source to confirm that the reserved bits stay zero.

// File: rtl/cir_irq_pkg.sv
package cir_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA    = 2'd0,
    OFS_ENABLE  = 2'd1,
    OFS_CAUSE   = 2'd2,
    OFS_RELEASE = 2'd3
  } ofs_e;

  // bit positions software decodes
  localparam int B_RXD  = 0;
  localparam int B_TXS  = 1;
  localparam int B_STOP = 2;
  localparam int B_OVR  = 3;
  localparam int B_DONE = 5;

  localparam logic [REG_W-1:0] LEVEL_MASK   = 8'b0000_0011;
  localparam logic [REG_W-1:0] STICKY_MASK  = 8'b0010_1100;
  localparam logic [REG_W-1:0] RELEASE_MASK = 8'b0000_1000;
  localparam logic [REG_W-1:0] LIVE_MASK    = LEVEL_MASK | STICKY_MASK;
endpackage

// File: rtl/cir_irq_level_sel.sv
module cir_irq_level_sel (
  input  logic fifo_on,
  input  logic direct_lvl,
  input  logic fifo_lvl,
  output logic lvl
);
  assign lvl = fifo_on ? fifo_lvl : direct_lvl;
endmodule

// File: rtl/cir_irq_sticky.sv
module cir_irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  a_r3_set_latches: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> q);
  a_r4_holds_without_clear: assert property (@(posedge clk) disable iff (rst)
    (q && !clr_i) |=> q);
endmodule

// File: rtl/cir_irq_regs.sv
module cir_irq_regs
  import cir_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  cause,
  input  logic [REG_W-1:0]  rx_data,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  enable,
  output logic              cause_rd,
  output logic              release_rd,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [REG_W-1:0]  tx_data
);
  logic [REG_W-1:0] rd_mux;

  assign cause_rd   = bus_rd && (bus_addr == OFS_CAUSE);
  assign release_rd = bus_rd && (bus_addr == OFS_RELEASE);
  assign rx_pop     = bus_rd && (bus_addr == OFS_DATA);
  assign tx_push    = bus_wr && (bus_addr == OFS_DATA);
  assign tx_data    = bus_wdata;

  always_comb begin
    unique case (bus_addr)
      OFS_DATA:    rd_mux = rx_data;
      OFS_ENABLE:  rd_mux = enable;
      OFS_CAUSE:   rd_mux = cause;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_ENABLE) enable <= bus_wdata & LIVE_MASK;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  a_r7_enable_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_ENABLE && !bus_wr) |=> bus_rdata == $past(enable));
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_CAUSE) |=> (bus_rdata[7:6] == 2'b00 && !bus_rdata[4]));
  a_r4_release_reads_zero: assert property (@(posedge clk) disable iff (rst)
    release_rd |=> bus_rdata == '0);
endmodule

// File: rtl/cir_irq_ctrl.sv
module cir_irq_ctrl
  import cir_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              fifo_on,
  input  logic              rx_ready,
  input  logic              rx_above_trig,
  input  logic              tx_empty,
  input  logic              tx_below_trig,
  input  logic              rx_stop_evt,
  input  logic              rx_ovr_evt,
  input  logic              tx_done_evt,
  input  logic [REG_W-1:0]  rx_data,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [REG_W-1:0]  tx_data,
  output logic              irq
);
  logic [REG_W-1:0] cause;
  logic [REG_W-1:0] enable;
  logic             cause_rd;
  logic             release_rd;

  for (genvar i = 0; i < REG_W; i++) begin : g_src
    if (i == B_RXD) begin : g_rx
      cir_irq_level_sel u_sel (.fifo_on(fifo_on), .direct_lvl(rx_ready),
                               .fifo_lvl(rx_above_trig), .lvl(cause[i]));
    end else if (i == B_TXS) begin : g_tx
      cir_irq_level_sel u_sel (.fifo_on(fifo_on), .direct_lvl(tx_empty),
                               .fifo_lvl(tx_below_trig), .lvl(cause[i]));
    end else if (STICKY_MASK[i]) begin : g_sticky
      logic set_ev;
      logic clr_ev;
      assign set_ev = (i == B_STOP) ? rx_stop_evt :
                      (i == B_OVR)  ? rx_ovr_evt  : tx_done_evt;
      assign clr_ev = RELEASE_MASK[i] ? release_rd : cause_rd;
      cir_irq_sticky u_bit (.clk(clk), .rst(rst), .set_i(set_ev),
                            .clr_i(clr_ev), .q(cause[i]));
    end else begin : g_unused
      assign cause[i] = 1'b0;
    end
  end

  cir_irq_regs u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cause(cause),
    .rx_data(rx_data), .bus_rdata(bus_rdata), .enable(enable),
    .cause_rd(cause_rd), .release_rd(release_rd), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_data(tx_data)
  );

  assign irq = |(cause & enable);

  a_r8_enabled_event_raises: assert property (@(posedge clk) disable iff (rst)
    (rx_stop_evt && enable[B_STOP] && !bus_wr) |=> irq);
  a_r4_cause_read_keeps_ovr: assert property (@(posedge clk) disable iff (rst)
    (cause[B_OVR] && cause_rd) |=> cause[B_OVR]);
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (enable == '0 && cause[B_OVR] == 1'b0 && bus_rdata == '0));
endmodule

// File: tb/test_cir_irq_ctrl.sv
module test_cir_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, rx_data = 8'h00, tx_data;
  logic       fifo_on = 0, rx_ready = 0, rx_above_trig = 0, tx_empty = 0, tx_below_trig = 0;
  logic       rx_stop_evt = 0, rx_ovr_evt = 0, tx_done_evt = 0;
  logic       rx_pop, tx_push, irq;
  int         n_chk = 0, n_err = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  cir_irq_ctrl i_cir_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_on(fifo_on),
    .rx_ready(rx_ready), .rx_above_trig(rx_above_trig), .tx_empty(tx_empty),
    .tx_below_trig(tx_below_trig), .rx_stop_evt(rx_stop_evt), .rx_ovr_evt(rx_ovr_evt),
    .tx_done_evt(tx_done_evt), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_data(tx_data), .irq(irq));

  // vector: {fifo_on, rx_ready, rx_above, tx_empty, tx_below, exp_bit1, exp_bit0}
  localparam logic [6:0] VEC [8] = '{
    7'b0_1_0_0_1_0_1, 7'b0_0_1_1_0_1_0, 7'b0_1_1_1_1_1_1, 7'b0_0_0_0_0_0_0,
    7'b1_1_0_0_1_1_0, 7'b1_0_1_1_0_0_1, 7'b1_1_1_0_0_0_1, 7'b1_0_0_1_1_1_0 };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 2) rx_stop_evt = 1; else if (which == 3) rx_ovr_evt = 1; else tx_done_evt = 1;
    @(negedge clk); rx_stop_evt = 0; rx_ovr_evt = 0; tx_done_evt = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 rdata", bus_rdata, 8'h00);
    check("R12 irq", {7'd0, irq}, 8'h00);
    bus_read(2'd1, rd); check("R7 enable reset", rd, 8'h00);
    bus_read(2'd2, rd); check("R12 cause reset", rd, 8'h00);

    // R1 R2 level sources table
    foreach (VEC[k]) begin
      {fifo_on, rx_ready, rx_above_trig, tx_empty, tx_below_trig} = VEC[k][6:2];
      bus_read(2'd2, rd);
      check((k % 2 == 0) ? "R1 R2 level" : "R2 R1 level", rd, {6'd0, VEC[k][1:0]});
    end
    {fifo_on, rx_ready, rx_above_trig, tx_empty, tx_below_trig} = 5'b0;
    bus_read(2'd2, rd); check("R1 level drops", rd, 8'h00);

    // R3 stop latches then clears on cause read
    pulse(2);
    bus_read(2'd2, rd); check("R3 stop set", rd, 8'h04);
    bus_read(2'd2, rd); check("R3 stop cleared", rd, 8'h00);
    // R5 tx done
    pulse(5);
    bus_read(2'd2, rd); check("R5 done set", rd, 8'h20);
    bus_read(2'd2, rd); check("R5 done cleared", rd, 8'h00);
    // R4 overrun survives cause read, cleared by release read
    pulse(3);
    bus_read(2'd2, rd); check("R4 ovr set", rd, 8'h08);
    bus_read(2'd2, rd); check("R4 ovr kept by cause read", rd, 8'h08);
    bus_read(2'd3, rd); check("R4 release reads zero", rd, 8'h00);
    bus_read(2'd2, rd); check("R4 ovr released", rd, 8'h00);

    // R9 set and clear in the same cycle
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1; rx_stop_evt = 1;
    @(negedge clk); bus_rd = 0; rx_stop_evt = 0;
    bus_read(2'd2, rd); check("R9 set wins", rd, 8'h04);

    // R8 latch while disabled, enable raises irq
    pulse(5);
    check("R8 irq off while disabled", {7'd0, irq}, 8'h00);
    bus_write(2'd1, 8'h20);
    check("R8 irq after enable", {7'd0, irq}, 8'h01);
    bus_read(2'd2, rd);
    check("R8 irq drops after clear", {7'd0, irq}, 8'h00);

    // R7 R6 enable mask and reserved bits
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd); check("R7 enable mask", rd, 8'h2F);
    rx_ready = 1; tx_empty = 1;
    pulse(2); pulse(3); pulse(5);
    bus_read(2'd2, rd); check("R6 reserved zero", rd, 8'h2F);
    rx_ready = 0; tx_empty = 0;
    bus_read(2'd3, rd);
    check("R8 irq idle", {7'd0, irq}, 8'h00);

    // R11 writes to 2 and 3 ignored, offset 0 push
    bus_write(2'd2, 8'hFF); bus_write(2'd3, 8'hFF);
    bus_read(2'd1, rd); check("R11 enable untouched", rd, 8'h2F);
    bus_read(2'd2, rd); check("R11 cause untouched", rd, 8'h00);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h3C; bus_wr = 1; #1;
    check("R11 tx_push", {7'd0, tx_push}, 8'h01);
    check("R11 tx_data", tx_data, 8'h3C);
    @(negedge clk); bus_wr = 0;

    // R10 data read
    rx_data = 8'hA5;
    @(negedge clk); bus_addr = 2'd0; bus_rd = 1; #1;
    check("R10 rx_pop", {7'd0, rx_pop}, 8'h01);
    @(negedge clk); bus_rd = 0;
    check("R10 rx data", bus_rdata, 8'hA5);

    // R12 reset mid-run
    pulse(3);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R12 rdata cleared", bus_rdata, 8'h00);
    bus_read(2'd2, rd); check("R12 sticky cleared", rd, 8'h00);
    bus_read(2'd1, rd); check("R12 enable cleared", rd, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule